// File: doc/BRIEF.md
# Permanent Failure Response Sequencer

This block carries out the ordered reaction of a battery monitor to a permanent-failure event. When the failure trigger arrives, the block takes a snapshot of a 16-bit configuration word and records whether a charge-FET or discharge-FET fault is active at that moment. Both the FET-off command and the regulator-off command are set one cycle later, if they are enabled, and they hold until reset. The block then works through its optional stages in a fixed order: fuse blow, then persistent status storage, then deep-sleep entry.

The fuse stage asks for a blow only while the monitored voltage is strictly above the minimum fuse-blow voltage. A configuration bit chooses which voltage is monitored: the top of the cell stack or the pack pin. A second bit lets a FET-fault cause skip the voltage test. The storage stage has two paths. It asks a nonvolatile-write agent to program the status when writes are allowed and the environment is suitable. When writes are not allowed, it saves the status to retained RAM instead. Deep sleep is asked for only after every earlier enabled stage has finished. Once the block leaves its idle state, it ignores any further trigger until reset.

Top module: `pf_sequencer`

## Requirements
- R1: While reset is held and directly after it, every output is low.
- R2: When `pfTrig` is high in the idle state, `fetOff` is set at the next clock edge if bit 1 of `cfgWord` is set, and `regOff` is set at that edge if bit 2 is set. Each one stays high until reset.
- R3: At the trigger, the configuration and the FET-fault cause are captured. After the block leaves idle, further triggers and changes to `cfgWord` have no effect.
- R4: The fuse stage runs only if bit 4 is set. In that stage, `fuseReq` is high exactly while the voltage condition holds: the monitored voltage must be strictly greater than `minFuseV`.
- R5: Bit 7 selects the monitored voltage. A value of 0 selects `stackV` and a value of 1 selects `packV`.
- R6: If bit 8 is set and either FET-fault input was high at the trigger, the voltage condition is met whatever the voltages are.
- R7: While the voltage condition fails, the fuse stage waits and tests it again on every cycle. The stage finishes only in a cycle where `fuseReq` and `fuseDone` are both high.
- R8: The storage stage runs only if bit 5 is set. If `nvWrEn` is high, `nvReq` is high while `nvEnvOk` is high. The stage finishes in a cycle where `nvReq` and `nvDone` are both high.
- R9: If bit 5 is set and `nvWrEn` is low, the storage stage produces a one-cycle `ramSave` pulse and no `nvReq`.
- R10: If bit 3 is set, `deepSleepReq` rises one cycle after the last enabled stage before it has finished, and it stays high until reset.
- R11: The stages run in this order: fuse, then storage, then sleep. Disabled stages are skipped, and at most one of `fuseReq`, `nvReq` and `ramSave` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pfTrig | input | 1 | Permanent-failure trigger |
| chgFetFail | input | 1 | Charge-FET fault indication |
| dsgFetFail | input | 1 | Discharge-FET fault indication |
| cfgWord | input | 16 | Response configuration word |
| stackV | input | 16 | Top-of-stack voltage |
| packV | input | 16 | Pack-pin voltage |
| minFuseV | input | 16 | Minimum fuse-blow voltage |
| nvWrEn | input | 1 | Nonvolatile writes allowed |
| nvEnvOk | input | 1 | Conditions suitable for programming |
| fuseDone | input | 1 | Fuse agent finished |
| nvDone | input | 1 | Nonvolatile-write agent finished |
| fetOff | output | 1 | FET-off command |
| regOff | output | 1 | Regulator-off command |
| fuseReq | output | 1 | Fuse-blow request |
| nvReq | output | 1 | Nonvolatile-write request |
| ramSave | output | 1 | Retained-RAM save strobe |
| deepSleepReq | output | 1 | Deep-sleep entry request |

## Verification
The difficult coincidence happens when the fuse agent reports completion in the same cycle that the monitored voltage falls to or below the minimum. The bench creates this case by raising `fuseDone` on the same edge where it lowers `stackV`. The block must stay in the fuse stage, and `fuseReq` must come back once the voltage recovers. The bench also sends a second trigger with a different configuration while the block is in the middle of a sequence, and checks that no output follows it. A behavioural model predicts all six outputs and is compared with the design on every clock.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACT     = 3'd1,
    ST_FUSE    = 3'd2,
    ST_NVWRITE = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_DONE    = 3'd5
  } seqState_e;

  localparam int BIT_FETS    = 1;
  localparam int BIT_REGS    = 2;
  localparam int BIT_SLEEP   = 3;
  localparam int BIT_FUSE    = 4;
  localparam int BIT_KEEP    = 5;
  localparam int BIT_PACKSEL = 7;
  localparam int BIT_BYPASS  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fuseReq;
    logic nvReq;
    logic ramSave;
    logic sleepSet;
  } seqStrobe_t;

  // enabled stages, taken from the captured configuration
  typedef struct packed {
    logic sleepEn;
    logic fuseEn;
    logic keepEn;
  } seqPlan_t;

endpackage

// File: rtl/pf_seq_dp.sv
module pf_seq_dp
  import pf_seq_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int VOLT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              chgFetFail,
  input  logic              dsgFetFail,
  input  logic [VOLT_W-1:0] stackV,
  input  logic [VOLT_W-1:0] packV,
  input  logic [VOLT_W-1:0] minFuseV,
  output seqPlan_t          plan,
  output logic              voltOk,
  output logic              fetOff,
  output logic              regOff,
  output logic              deepSleepReq,
  output logic              fuseReq,
  output logic              nvReq,
  output logic              ramSave
);

  logic [CFG_W-1:0]  cfgHold;
  logic              fetCause;
  logic [VOLT_W-1:0] monV;
  logic              aboveMin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgHold  <= '0;
      fetCause <= 1'b0;
      fetOff   <= 1'b0;
      regOff   <= 1'b0;
    end else if (strobe.capture) begin
      cfgHold  <= cfgWord;
      fetCause <= chgFetFail | dsgFetFail;
      fetOff   <= cfgWord[BIT_FETS];
      regOff   <= cfgWord[BIT_REGS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deepSleepReq <= 1'b0;
    else if (strobe.sleepSet) deepSleepReq <= 1'b1;
  end

  assign monV     = cfgHold[BIT_PACKSEL] ? packV : stackV;
  assign aboveMin = monV > minFuseV;
  assign voltOk   = aboveMin | (cfgHold[BIT_BYPASS] & fetCause);

  assign plan.sleepEn = cfgHold[BIT_SLEEP];
  assign plan.fuseEn  = cfgHold[BIT_FUSE];
  assign plan.keepEn  = cfgHold[BIT_KEEP];

  assign fuseReq = strobe.fuseReq;
  assign nvReq   = strobe.nvReq;
  assign ramSave = strobe.ramSave;

  assert_fet_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetOff |=> fetOff);
  assert_reg_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    regOff |=> regOff);
  assert_sleep_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    deepSleepReq |=> deepSleepReq);
  assert_sleep_after_stages_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deepSleepReq) |-> $past(!fuseReq && !nvReq));
  assert_ram_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramSave |=> !ramSave);

endmodule

// File: rtl/pf_seq_ctrl.sv
module pf_seq_ctrl
  import pf_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pfTrig,
  input  seqPlan_t   plan,
  input  logic       voltOk,
  input  logic       fuseDone,
  input  logic       nvWrEn,
  input  logic       nvEnvOk,
  input  logic       nvDone,
  output seqStrobe_t strobe
);

  seqState_e state, stateNext;

  // first enabled stage strictly after the given one
  function automatic seqState_e stageAfter(seqState_e from, seqPlan_t p);
    seqState_e r;
    r = ST_DONE;
    if (from == ST_ACT && p.fuseEn) r = ST_FUSE;
    else if ((from == ST_ACT || from == ST_FUSE) && p.keepEn) r = ST_NVWRITE;
    else if (from != ST_SLEEP && p.sleepEn) r = ST_SLEEP;
    return r;
  endfunction

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (pfTrig) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ACT;
        end
      end
      ST_ACT: stateNext = stageAfter(ST_ACT, plan);
      ST_FUSE: begin
        strobe.fuseReq = voltOk;
        if (voltOk && fuseDone) stateNext = stageAfter(ST_FUSE, plan);
      end
      ST_NVWRITE: begin
        if (!nvWrEn) begin
          strobe.ramSave = 1'b1;
          stateNext      = stageAfter(ST_NVWRITE, plan);
        end else begin
          strobe.nvReq = nvEnvOk;
          if (nvEnvOk && nvDone) stateNext = stageAfter(ST_NVWRITE, plan);
        end
      end
      ST_SLEEP: begin
        strobe.sleepSet = 1'b1;
        stateNext       = ST_DONE;
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_no_return_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_IDLE));
  assert_one_stage_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.fuseReq, strobe.nvReq, strobe.ramSave}));
  assert_done_terminal_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE));
  assert_fuse_needs_en_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FUSE) |-> plan.fuseEn);

endmodule

// File: rtl/pf_sequencer.sv
module pf_sequencer
  import pf_seq_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int VOLT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pfTrig,
  input  logic              chgFetFail,
  input  logic              dsgFetFail,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [VOLT_W-1:0] stackV,
  input  logic [VOLT_W-1:0] packV,
  input  logic [VOLT_W-1:0] minFuseV,
  input  logic              nvWrEn,
  input  logic              nvEnvOk,
  input  logic              fuseDone,
  input  logic              nvDone,
  output logic              fetOff,
  output logic              regOff,
  output logic              fuseReq,
  output logic              nvReq,
  output logic              ramSave,
  output logic              deepSleepReq
);

  seqStrobe_t strobe;
  seqPlan_t   plan;
  logic       voltOk;

  pf_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pfTrig  (pfTrig),
    .plan    (plan),
    .voltOk  (voltOk),
    .fuseDone(fuseDone),
    .nvWrEn  (nvWrEn),
    .nvEnvOk (nvEnvOk),
    .nvDone  (nvDone),
    .strobe  (strobe)
  );

  pf_seq_dp #(.CFG_W(CFG_W), .VOLT_W(VOLT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgWord     (cfgWord),
    .chgFetFail  (chgFetFail),
    .dsgFetFail  (dsgFetFail),
    .stackV      (stackV),
    .packV       (packV),
    .minFuseV    (minFuseV),
    .plan        (plan),
    .voltOk      (voltOk),
    .fetOff      (fetOff),
    .regOff      (regOff),
    .deepSleepReq(deepSleepReq),
    .fuseReq     (fuseReq),
    .nvReq       (nvReq),
    .ramSave     (ramSave)
  );

endmodule

// File: tb/test_pf_sequencer.sv
module test_pf_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfTrig = 1'b0, chgFetFail = 1'b0, dsgFetFail = 1'b0;
  logic [15:0] cfgWord = 16'h0002;
  logic [15:0] stackV = '0, packV = '0, minFuseV = 16'd200;
  logic nvWrEn = 1'b0, nvEnvOk = 1'b0, fuseDone = 1'b0, nvDone = 1'b0;
  logic fetOff, regOff, fuseReq, nvReq, ramSave, deepSleepReq;

  int total = 0, bad = 0, cycles = 0;

  pf_sequencer i_pf_sequencer (
    .clk(clk), .rstN(rstN), .pfTrig(pfTrig), .chgFetFail(chgFetFail),
    .dsgFetFail(dsgFetFail), .cfgWord(cfgWord), .stackV(stackV), .packV(packV),
    .minFuseV(minFuseV), .nvWrEn(nvWrEn), .nvEnvOk(nvEnvOk), .fuseDone(fuseDone),
    .nvDone(nvDone), .fetOff(fetOff), .regOff(regOff), .fuseReq(fuseReq),
    .nvReq(nvReq), .ramSave(ramSave), .deepSleepReq(deepSleepReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 idle, 1 act, 2 fuse, 3 store, 4 sleep, 5 done
  int mSt;
  logic [15:0] mCfg;
  bit mCause, mFet, mReg, mSleep;

  function automatic bit mVoltOk();
    int v;
    v = mCfg[7] ? int'(packV) : int'(stackV);
    return (mCfg[8] && mCause) || (v > int'(minFuseV));
  endfunction

  function automatic int mNext(int from);
    if (from < 2 && mCfg[4]) return 2;
    if (from < 3 && mCfg[5]) return 3;
    if (from < 4 && mCfg[3]) return 4;
    return 5;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCfg = '0; mCause = 0; mFet = 0; mReg = 0; mSleep = 0;
    end else begin
      case (mSt)
        0: if (pfTrig) begin
             mCfg = cfgWord; mCause = chgFetFail || dsgFetFail;
             mFet = cfgWord[1]; mReg = cfgWord[2]; mSt = 1;
           end
        1: mSt = mNext(1);
        2: if (mVoltOk() && fuseDone) mSt = mNext(2);
        3: if (!nvWrEn || (nvEnvOk && nvDone)) mSt = mNext(3);
        4: begin mSleep = 1; mSt = 5; end
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    chk("R2 fetOff", fetOff, mFet);
    chk("R2 regOff", regOff, mReg);
    chk("R4 fuseReq", fuseReq, mSt == 2 && mVoltOk());
    chk("R8 nvReq", nvReq, mSt == 3 && nvWrEn && nvEnvOk);
    chk("R9 ramSave", ramSave, mSt == 3 && !nvWrEn);
    chk("R10 deepSleepReq", deepSleepReq, mSleep);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic atNeg();
    @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; pfTrig = 0; fuseDone = 0; nvDone = 0;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic trigger(logic [15:0] cfg);
    cfgWord = cfg; pfTrig = 1'b1;
    step(1);
    pfTrig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1);
    atNeg();
    // R1: reset state
    chk("R1 fetOff", fetOff, 0); chk("R1 fuseReq", fuseReq, 0);
    chk("R1 deepSleepReq", deepSleepReq, 0);
    doReset();
    atNeg();
    chk("R1 regOff", regOff, 0); chk("R1 ramSave", ramSave, 0);

    // default config: FETs only; then a retrigger must be ignored (R3)
    step(1);
    trigger(16'h0002);
    atNeg(); chk("R2 fetOff set", fetOff, 1); chk("R2 regOff clear", regOff, 0);
    step(3);
    trigger(16'h003E);
    step(3); atNeg();
    chk("R3 regOff after retrigger", regOff, 0);
    chk("R3 fuseReq after retrigger", fuseReq, 0);
    chk("R3 deepSleepReq after retrigger", deepSleepReq, 0);

    // fuse on stack voltage, waiting for voltage (R7)
    doReset(); stackV = 16'd100; packV = 16'd500;
    trigger(16'h0014);
    step(4); atNeg();
    chk("R7 fuseReq waits low stack", fuseReq, 0);
    chk("R2 regOff set", regOff, 1);
    step(1); stackV = 16'd200; atNeg();
    chk("R4 equal is not above", fuseReq, 0);
    step(1); stackV = 16'd201; atNeg();
    chk("R4 fuseReq above min", fuseReq, 1);
    step(1); fuseDone = 1; step(1); fuseDone = 0; atNeg();
    chk("R7 fuse stage finished", fuseReq, 0);

    // pack select (R5)
    doReset(); stackV = 16'd900; packV = 16'd50;
    trigger(16'h0090);
    step(2); atNeg();
    chk("R5 pack low ignores high stack", fuseReq, 0);
    step(1); packV = 16'd300; atNeg();
    chk("R5 pack high", fuseReq, 1);
    fuseDone = 1; step(1); fuseDone = 0;

    // bypass with FET cause (R6), then without cause
    doReset(); stackV = 16'd10; packV = 16'd10; chgFetFail = 1;
    trigger(16'h0110); chgFetFail = 0;
    step(1); atNeg();
    chk("R6 bypass with charge fault", fuseReq, 1);
    fuseDone = 1; step(1); fuseDone = 0;
    doReset(); dsgFetFail = 0;
    trigger(16'h0110);
    step(1); atNeg();
    chk("R6 no bypass without fault", fuseReq, 0);

    // full order fuse -> store -> sleep (R11), with env wait (R8)
    doReset(); stackV = 16'd500; nvWrEn = 1; nvEnvOk = 0;
    trigger(16'h003A);
    step(1); atNeg(); chk("R11 fuse first", fuseReq, 1);
    fuseDone = 1; step(1); fuseDone = 0;
    step(3); atNeg();
    chk("R8 nvReq waits env", nvReq, 0);
    chk("R10 no sleep before store", deepSleepReq, 0);
    nvEnvOk = 1; atNeg(); chk("R8 nvReq env ok", nvReq, 1);
    step(1); nvDone = 1; step(1); nvDone = 0;
    step(1); atNeg();
    chk("R10 sleep after stages", deepSleepReq, 1);
    chk("R11 no requests at end", nvReq | fuseReq, 0);

    // retained-RAM path (R9)
    doReset(); nvWrEn = 0;
    trigger(16'h0028);
    step(1); atNeg();
    chk("R9 ramSave pulse", ramSave, 1);
    chk("R9 no nvReq", nvReq, 0);
    step(1); atNeg(); chk("R9 pulse one cycle", ramSave, 0);

    // coincidence: fuseDone with voltage dropping (R7)
    doReset(); stackV = 16'd400;
    trigger(16'h0018);
    step(2);
    stackV = 16'd100; fuseDone = 1;
    step(1); fuseDone = 0; stackV = 16'd400; atNeg();
    chk("R7 done with low voltage does not advance", fuseReq, 1);
    fuseDone = 1; step(1); fuseDone = 0;
    step(2); atNeg();
    chk("R10 sleep after fuse", deepSleepReq, 1);

    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule